// File: doc/BRIEF.md
# Deflection Soft-Start and Protection Sequencer

This block sequences the power-up, soft start, shutdown and fault handling of a display deflection controller's drive outputs. A digital ramp counter takes the place of the charged soft-start capacitor. While the soft-start control bit is set and the supply is healthy, the ramp climbs at a fixed rate. It then releases the outputs in stages. The vertical outputs come first. Horizontal drive follows, starting with a one-step duty limit that widens as the ramp rises. B+ drive then starts the same way. Last, when the ramp reaches its operating level, it stops and enables the PLL2 and lock loops.

Every protection source forces the ramp back to zero in one clock. These sources are a cleared soft-start bit, an external pull-down, a supply dip, low-supply standby and a qualified X-ray fault. Each source has its own recovery path. In the hard-latch configuration, an X-ray fault is cleared only by a supply power cycle. The block also gates the bus acknowledge while the supply is below the level at which writes are accepted.

Top module: `sseq_softstart_ctrl`

## Requirements
- R1: `i2c_ack_en` follows `ack_window`. While `ack_window` is 0, the soft-start bit is held cleared and soft-start writes are ignored. A write made then starts nothing after the window reopens.
- R2: After reset, and until a soft-start write of 1, the following outputs are 0: `vert_en`, `hdrv_en`, `hdrv_duty`, `bplus_en`, `bplus_duty` and `loops_en`. In the same period, `blank_cont` and `unlock_float` are 1.
- R3: Count the clock edges after the edge that sets the soft-start bit, with `supply_code` = 2'b10 (at or above the soft-start level). The ramp level is that count divided by RAMP_DIV, rounded down, and it saturates at RUN_LVL. `vert_en` rises when the ramp reaches VERT_LVL.
- R4: `hdrv_en` rises at ramp level HOR_LVL with `hdrv_duty` = 1. The duty grows by one per ramp step and holds at HDUTY_FULL.
- R5: `bplus_en` rises at ramp level BPLUS_LVL = HOR_LVL + HDUTY_FULL with `bplus_duty` = 1. That duty grows by one per step up to BDUTY_FULL. At RUN_LVL = BPLUS_LVL + BDUTY_FULL the ramp stops and `loops_en` rises.
- R6: `blank_cont` and `unlock_float` go to 0 only while `loops_en` and `loops_locked` are both 1. They return to 1 when either drops.
- R7: A soft-start write of 0 turns off all drive outputs and `loops_en` from the next clock. It also sets `blank_cont` and `unlock_float` to 1.
- R8: While `ext_pulldown` is 1, `hdrv_en`, `bplus_en` and `loops_en` are 0 at once and the ramp is cleared, while `vert_en` stays 1. On release the ramp restarts from zero, and `vert_en` stays 1 throughout.
- R9: Encodings: `supply_code` 2'b00 or 2'b11 means below the dip level, and 2'b01 means between the dip level and the soft-start level. A dip code clears the soft-start bit at the next edge. The outputs stay off after the supply recovers until a new soft-start write of 1.
- R10: An X-ray trip occurs only after `xray_hi` has been sampled 1 on XRAY_QUAL consecutive edges, and it clears the soft-start bit at that edge. A shorter burst has no effect.
- R11: With `xray_hard_sel` = 0, a soft-start write of 1 made after `xray_hi` falls restarts the full ramp.
- R12: With `xray_hard_sel` = 1, a trip latches. Soft-start writes of 1 are then ignored until `supply_code` shows a dip, after which a write restarts the ramp.
- R13: With `supply_code` = 2'b01, a set soft-start bit does not advance the ramp. The ramp starts counting from the first edge after the code changes to 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_code | input | 2 | Supply level code (see R9, R13) |
| ack_window | input | 1 | Supply is above the write-acceptance level |
| xray_hi | input | 1 | X-ray comparator above threshold |
| xray_hard_sel | input | 1 | 1: an X-ray trip latches until a power cycle |
| ext_pulldown | input | 1 | Soft-start node pulled low externally |
| ss_wr_en | input | 1 | Bus write strobe for the soft-start bit |
| ss_wr_data | input | 1 | Value written to the soft-start bit |
| loops_locked | input | 1 | PLL2 and lock loop report normal operation |
| i2c_ack_en | output | 1 | Bus acknowledge permitted |
| vert_en | output | 1 | Vertical output stages enabled |
| hdrv_en | output | 1 | Horizontal drive enabled |
| hdrv_duty | output | $clog2(HDUTY_FULL+1) | Horizontal duty-cycle limit step |
| bplus_en | output | 1 | B+ drive enabled |
| bplus_duty | output | $clog2(BDUTY_FULL+1) | B+ duty-cycle limit step |
| loops_en | output | 1 | PLL2 and lock loop enabled |
| unlock_float | output | 1 | Unlock output floating |
| blank_cont | output | 1 | Continuous blanking forced |

## Verification
The bench builds the sequencer with RAMP_DIV = 3, VERT_LVL = 4, HOR_LVL = 6, HDUTY_FULL = 5, BDUTY_FULL = 4 and XRAY_QUAL = 8. With these values the whole ramp to RUN_LVL = 15 takes 45 edges. Every duty step and stage boundary can therefore be compared cycle by cycle against the edge-count model. The short qualification window allows both a 7-edge burst and an 8-edge trip. Each start, protection and restart path runs many times within the cycle limit.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [1:0] {
        SUP_DIP  = 2'b00,
        SUP_MID  = 2'b01,
        SUP_GOOD = 2'b10,
        SUP_BAD  = 2'b11
    } supply_e;

    // Any code at or below the dip level (the unused code counts as a dip).
    function automatic logic supply_dip(input logic [1:0] code);
        return (code == SUP_DIP) || (code == SUP_BAD);
    endfunction

    function automatic logic supply_can_ramp(input logic [1:0] code);
        return code == SUP_GOOD;
    endfunction

    // Clear request for the soft-start bit, one field per source.
    typedef struct packed {
        logic standby;
        logic dip;
        logic xray;
    } ss_clear_t;

endpackage

// File: rtl/sseq_xray_guard.sv
module sseq_xray_guard #(
    parameter int QUAL = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic xray_hi,
    input  logic hard_sel,
    input  logic power_dip,
    output logic trip,
    output logic hard_lock
);
    localparam int QW = (QUAL > 1) ? $clog2(QUAL) : 1;
    localparam logic [QW-1:0] LAST = QW'(QUAL - 1);

    logic [QW-1:0] run_q;
    logic          lock_q;

    // Trip on the edge where the comparator completes QUAL consecutive samples.
    assign trip      = xray_hi && (run_q == LAST);
    assign hard_lock = lock_q;

    always_ff @(posedge clk) begin
        if (rst || !xray_hi) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    // The latch survives everything except reset and a supply dip.
    always_ff @(posedge clk) begin
        if (rst || power_dip) begin
            lock_q <= 1'b0;
        end else if (trip && hard_sel) begin
            lock_q <= 1'b1;
        end
    end

endmodule

// File: rtl/sseq_ramp.sv
module sseq_ramp #(
    parameter int DIV = 64,
    parameter int TOP = 49,
    parameter int RW  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          discharge,
    input  logic          charge_ok,
    output logic [RW-1:0] level
);
    localparam int DVW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DVW-1:0] DIV_LAST = DVW'(DIV - 1);
    localparam logic [RW-1:0]  TOP_R    = RW'(TOP);

    logic [DVW-1:0] div_q;
    logic [RW-1:0]  level_q;

    assign level = level_q;

    always_ff @(posedge clk) begin
        if (rst || discharge) begin
            div_q   <= '0;
            level_q <= '0;
        end else if (charge_ok && (level_q != TOP_R)) begin
            if (div_q == DIV_LAST) begin
                div_q   <= '0;
                level_q <= level_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sseq_duty_ch.sv
module sseq_duty_ch #(
    parameter int RW    = 6,
    parameter int START = 17,
    parameter int FULL  = 16,
    parameter int DW    = 5
) (
    input  logic [RW-1:0] level,
    input  logic          gate,
    output logic          en,
    output logic [DW-1:0] duty
);
    localparam logic [RW-1:0] START_R = RW'(START);
    localparam logic [RW:0]   FULL_X  = (RW+1)'(FULL);
    localparam logic [DW-1:0] FULL_D  = DW'(FULL);

    logic [RW:0] rel;

    always_comb begin
        rel  = {1'b0, level} - {1'b0, START_R} + (RW+1)'(1);
        en   = gate && (level >= START_R);
        duty = '0;
        if (en) begin
            duty = (rel >= FULL_X) ? FULL_D : DW'(rel);
        end
    end

endmodule

// File: rtl/sseq_softstart_ctrl.sv
module sseq_softstart_ctrl #(
    parameter int RAMP_DIV   = 64,
    parameter int VERT_LVL   = 11,
    parameter int HOR_LVL    = 17,
    parameter int HDUTY_FULL = 16,
    parameter int BDUTY_FULL = 16,
    parameter int XRAY_QUAL  = 1000,
    localparam int HDW = $clog2(HDUTY_FULL + 1),
    localparam int BDW = $clog2(BDUTY_FULL + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     supply_code,
    input  logic           ack_window,
    input  logic           xray_hi,
    input  logic           xray_hard_sel,
    input  logic           ext_pulldown,
    input  logic           ss_wr_en,
    input  logic           ss_wr_data,
    input  logic           loops_locked,
    output logic           i2c_ack_en,
    output logic           vert_en,
    output logic           hdrv_en,
    output logic [HDW-1:0] hdrv_duty,
    output logic           bplus_en,
    output logic [BDW-1:0] bplus_duty,
    output logic           loops_en,
    output logic           unlock_float,
    output logic           blank_cont
);
    import sseq_pkg::*;

    localparam int BPLUS_LVL = HOR_LVL + HDUTY_FULL;
    localparam int RUN_LVL   = BPLUS_LVL + BDUTY_FULL;
    localparam int RW        = $clog2(RUN_LVL + 1);
    localparam logic [RW-1:0] VERT_R = RW'(VERT_LVL);
    localparam logic [RW-1:0] RUN_R  = RW'(RUN_LVL);

    ss_clear_t     clr;
    logic          dip;
    logic          trip;
    logic          hard_lock;
    logic          ss_q;
    logic          varm_q;
    logic          run_ok;
    logic          normal;
    logic [RW-1:0] level;

    assign dip = supply_dip(supply_code);

    always_comb begin
        clr.standby = !ack_window;
        clr.dip     = dip;
        clr.xray    = trip;
    end

    sseq_xray_guard #(
        .QUAL(XRAY_QUAL)
    ) u_xray (
        .clk      (clk),
        .rst      (rst),
        .xray_hi  (xray_hi),
        .hard_sel (xray_hard_sel),
        .power_dip(dip),
        .trip     (trip),
        .hard_lock(hard_lock)
    );

    // Soft-start control bit: any clear source wins over a bus write.
    always_ff @(posedge clk) begin
        if (rst || (|clr)) begin
            ss_q <= 1'b0;
        end else if (ss_wr_en) begin
            ss_q <= ss_wr_data && !hard_lock;
        end
    end

    assign run_ok = ss_q && !ext_pulldown;

    sseq_ramp #(
        .DIV(RAMP_DIV),
        .TOP(RUN_LVL),
        .RW (RW)
    ) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .discharge(!run_ok),
        .charge_ok(supply_can_ramp(supply_code)),
        .level    (level)
    );

    // Vertical stages stay armed through an external pull-down.
    always_ff @(posedge clk) begin
        if (rst || !ss_q) begin
            varm_q <= 1'b0;
        end else if (level >= VERT_R) begin
            varm_q <= 1'b1;
        end
    end

    assign vert_en = ss_q && (varm_q || (level >= VERT_R));

    sseq_duty_ch #(
        .RW   (RW),
        .START(HOR_LVL),
        .FULL (HDUTY_FULL),
        .DW   (HDW)
    ) u_hdrv (
        .level(level),
        .gate (run_ok),
        .en   (hdrv_en),
        .duty (hdrv_duty)
    );

    sseq_duty_ch #(
        .RW   (RW),
        .START(BPLUS_LVL),
        .FULL (BDUTY_FULL),
        .DW   (BDW)
    ) u_bplus (
        .level(level),
        .gate (run_ok),
        .en   (bplus_en),
        .duty (bplus_duty)
    );

    assign loops_en     = run_ok && (level == RUN_R);
    assign normal       = loops_en && loops_locked;
    assign blank_cont   = !normal;
    assign unlock_float = !normal;
    assign i2c_ack_en   = ack_window;

endmodule

// File: rtl/sseq_softstart_ctrl_chk.sv
module sseq_softstart_ctrl_chk #(
    parameter int HDUTY_FULL = 16,
    parameter int BDUTY_FULL = 16,
    parameter int HDW = 5,
    parameter int BDW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic [1:0]     supply_code,
    input logic           ack_window,
    input logic           vert_en,
    input logic           hdrv_en,
    input logic [HDW-1:0] hdrv_duty,
    input logic           bplus_en,
    input logic [BDW-1:0] bplus_duty,
    input logic           loops_en,
    input logic           blank_cont
);
    localparam logic [HDW-1:0] HFULL = HDW'(HDUTY_FULL);
    localparam logic [BDW-1:0] BFULL = BDW'(BDUTY_FULL);

    p_vert_first_r3: assert property (@(posedge clk) disable iff (rst)
        hdrv_en |-> vert_en);

    p_duty_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (hdrv_en && $past(hdrv_en)) |-> (hdrv_duty >= $past(hdrv_duty)));

    p_duty_step_r4: assert property (@(posedge clk) disable iff (rst)
        (hdrv_en && $past(hdrv_en)) |-> ((hdrv_duty - $past(hdrv_duty)) <= HDW'(1)));

    p_hfull_first_r5: assert property (@(posedge clk) disable iff (rst)
        bplus_en |-> (hdrv_duty == HFULL));

    p_bfull_first_r5: assert property (@(posedge clk) disable iff (rst)
        loops_en |-> (bplus_duty == BFULL));

    p_unblank_r6: assert property (@(posedge clk) disable iff (rst)
        !blank_cont |-> (vert_en && hdrv_en && bplus_en));

    p_standby_r1: assert property (@(posedge clk) disable iff (rst)
        !ack_window |=> !vert_en);

    p_dip_off_r9: assert property (@(posedge clk) disable iff (rst)
        ((supply_code == 2'b00) || (supply_code == 2'b11)) |=> !vert_en);

endmodule

bind sseq_softstart_ctrl sseq_softstart_ctrl_chk #(
    .HDUTY_FULL(HDUTY_FULL),
    .BDUTY_FULL(BDUTY_FULL),
    .HDW       (HDW),
    .BDW       (BDW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_code(supply_code),
    .ack_window (ack_window),
    .vert_en    (vert_en),
    .hdrv_en    (hdrv_en),
    .hdrv_duty  (hdrv_duty),
    .bplus_en   (bplus_en),
    .bplus_duty (bplus_duty),
    .loops_en   (loops_en),
    .blank_cont (blank_cont)
);

// File: tb/sseq_softstart_ctrl_bench.sv
module sseq_softstart_ctrl_bench;

    localparam int DIV   = 3;
    localparam int VERT  = 4;
    localparam int HOR   = 6;
    localparam int HF    = 5;
    localparam int BF    = 4;
    localparam int XQ    = 8;
    localparam int BPLUS = HOR + HF;
    localparam int RUN   = BPLUS + BF;
    localparam int HDW   = $clog2(HF + 1);
    localparam int BDW   = $clog2(BF + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     supply_code = 2'b10;
    logic           ack_window = 1'b1;
    logic           xray_hi = 1'b0;
    logic           xray_hard_sel = 1'b0;
    logic           ext_pulldown = 1'b0;
    logic           ss_wr_en = 1'b0;
    logic           ss_wr_data = 1'b0;
    logic           loops_locked = 1'b0;
    logic           i2c_ack_en, vert_en, hdrv_en, bplus_en, loops_en;
    logic           unlock_float, blank_cont;
    logic [HDW-1:0] hdrv_duty;
    logic [BDW-1:0] bplus_duty;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sseq_softstart_ctrl #(
        .RAMP_DIV  (DIV),
        .VERT_LVL  (VERT),
        .HOR_LVL   (HOR),
        .HDUTY_FULL(HF),
        .BDUTY_FULL(BF),
        .XRAY_QUAL (XQ)
    ) u_sseq_softstart_ctrl (
        .clk          (clk),
        .rst          (rst),
        .supply_code  (supply_code),
        .ack_window   (ack_window),
        .xray_hi      (xray_hi),
        .xray_hard_sel(xray_hard_sel),
        .ext_pulldown (ext_pulldown),
        .ss_wr_en     (ss_wr_en),
        .ss_wr_data   (ss_wr_data),
        .loops_locked (loops_locked),
        .i2c_ack_en   (i2c_ack_en),
        .vert_en      (vert_en),
        .hdrv_en      (hdrv_en),
        .hdrv_duty    (hdrv_duty),
        .bplus_en     (bplus_en),
        .bplus_duty   (bplus_duty),
        .loops_en     (loops_en),
        .unlock_float (unlock_float),
        .blank_cont   (blank_cont)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_duty(input int r, input int s, input int f);
        if (r < s) return 0;
        return (r - s + 1 > f) ? f : r - s + 1;
    endfunction

    task automatic all_off(input string req);
        chk(req, "vert_en", int'(vert_en), 0);
        chk(req, "hdrv_en", int'(hdrv_en), 0);
        chk(req, "hdrv_duty", int'(hdrv_duty), 0);
        chk(req, "bplus_en", int'(bplus_en), 0);
        chk(req, "bplus_duty", int'(bplus_duty), 0);
        chk(req, "loops_en", int'(loops_en), 0);
        chk(req, "blank_cont", int'(blank_cont), 1);
        chk(req, "unlock_float", int'(unlock_float), 1);
    endtask

    // Leaves the bench at the falling edge right after the write edge.
    task automatic ss_write(input logic v);
        @(negedge clk);
        ss_wr_en   = 1'b1;
        ss_wr_data = v;
        @(negedge clk);
        ss_wr_en   = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Caller stands at a falling edge with zero counting edges behind it.
    task automatic ramp_check(input string tag, input bit vpre);
        for (int n = 0; n <= RUN * DIV + 2; n++) begin
            int r;
            if (n > 0) @(negedge clk);
            #1;
            r = n / DIV;
            if (r > RUN) r = RUN;
            chk({tag, " R3"}, "vert_en", int'(vert_en), int'(vpre || r >= VERT));
            chk({tag, " R4"}, "hdrv_en", int'(hdrv_en), int'(r >= HOR));
            chk({tag, " R4"}, "hdrv_duty", int'(hdrv_duty), exp_duty(r, HOR, HF));
            chk({tag, " R5"}, "bplus_en", int'(bplus_en), int'(r >= BPLUS));
            chk({tag, " R5"}, "bplus_duty", int'(bplus_duty), exp_duty(r, BPLUS, BF));
            chk({tag, " R5"}, "loops_en", int'(loops_en), int'(r == RUN));
            chk({tag, " R6"}, "blank_cont", int'(blank_cont),
                int'(!(r == RUN && loops_locked)));
        end
    endtask

    task automatic t_reset;
        #1;
        all_off("R2 reset");
        chk("R1", "i2c_ack_en", int'(i2c_ack_en), 1);
    endtask

    task automatic t_standby;
        @(negedge clk);
        ack_window = 1'b0;
        #1;
        chk("R1", "i2c_ack_en low", int'(i2c_ack_en), 0);
        ss_write(1'b1);
        ack_window = 1'b1;
        wait_cycles(3 * RUN * DIV);
        #1;
        all_off("R1 ignored write");
        all_off("R2 idle");
    endtask

    task automatic t_startup;
        loops_locked = 1'b0;
        ss_write(1'b1);
        ramp_check("startup", 1'b0);
    endtask

    task automatic t_lock;
        @(negedge clk);
        loops_locked = 1'b1;
        #1;
        chk("R6", "blank_cont locked", int'(blank_cont), 0);
        chk("R6", "unlock_float locked", int'(unlock_float), 0);
        @(negedge clk);
        loops_locked = 1'b0;
        #1;
        chk("R6", "blank_cont unlocked", int'(blank_cont), 1);
        loops_locked = 1'b1;
    endtask

    task automatic t_clear_bit;
        ss_write(1'b0);
        #1;
        all_off("R7");
    endtask

    task automatic t_pulldown;
        ss_write(1'b1);
        ramp_check("R8 pre", 1'b0);
        @(negedge clk);
        ext_pulldown = 1'b1;
        #1;
        chk("R8", "hdrv_en", int'(hdrv_en), 0);
        chk("R8", "bplus_en", int'(bplus_en), 0);
        chk("R8", "loops_en", int'(loops_en), 0);
        chk("R8", "vert_en", int'(vert_en), 1);
        chk("R8", "blank_cont", int'(blank_cont), 1);
        chk("R8", "unlock_float", int'(unlock_float), 1);
        wait_cycles(10);
        #1;
        chk("R8", "vert_en held", int'(vert_en), 1);
        chk("R8", "hdrv_en held", int'(hdrv_en), 0);
        @(negedge clk);
        ext_pulldown = 1'b0;
        ramp_check("R8 release", 1'b1);
    endtask

    task automatic t_ack_drop;
        @(negedge clk);
        ack_window = 1'b0;
        #1;
        chk("R1", "i2c_ack_en drop", int'(i2c_ack_en), 0);
        @(negedge clk);
        ack_window = 1'b1;
        #1;
        all_off("R1 standby");
    endtask

    task automatic t_dip;
        ss_write(1'b1);
        ramp_check("R9 pre", 1'b0);
        @(negedge clk);
        supply_code = 2'b00;
        @(negedge clk);
        supply_code = 2'b10;
        #1;
        all_off("R9 dip");
        wait_cycles(3 * RUN * DIV);
        #1;
        all_off("R9 stays off");
        ss_write(1'b1);
        ramp_check("R9 reload", 1'b0);
    endtask

    task automatic xray_burst(input int edges);
        @(negedge clk);
        xray_hi = 1'b1;
        wait_cycles(edges);
        xray_hi = 1'b0;
        #1;
    endtask

    task automatic t_xray_short;
        xray_burst(XQ - 1);
        chk("R10", "vert_en after short burst", int'(vert_en), 1);
        chk("R10", "loops_en after short burst", int'(loops_en), 1);
        wait_cycles(4);
        #1;
        chk("R10", "hdrv_duty after short burst", int'(hdrv_duty), HF);
    endtask

    task automatic t_xray_soft;
        xray_hard_sel = 1'b0;
        xray_burst(XQ);
        all_off("R10 trip");
        ss_write(1'b1);
        ramp_check("R11 restart", 1'b0);
    endtask

    task automatic t_xray_hard;
        xray_hard_sel = 1'b1;
        xray_burst(XQ);
        all_off("R12 trip");
        ss_write(1'b1);
        wait_cycles(3 * RUN * DIV);
        #1;
        all_off("R12 write ignored");
        @(negedge clk);
        supply_code = 2'b11;
        @(negedge clk);
        supply_code = 2'b10;
        xray_hard_sel = 1'b0;
        ss_write(1'b1);
        ramp_check("R12 power cycle", 1'b0);
    endtask

    task automatic t_mid;
        ss_write(1'b0);
        @(negedge clk);
        supply_code = 2'b01;
        ss_write(1'b1);
        wait_cycles(3 * RUN * DIV);
        #1;
        all_off("R13 held");
        @(negedge clk);
        supply_code = 2'b10;
        ramp_check("R13 go", 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_standby();
        t_startup();
        t_lock();
        t_clear_bit();
        t_pulldown();
        t_ack_drop();
        t_dip();
        t_xray_short();
        t_xray_soft();
        t_xray_hard();
        t_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule